// File: doc/BRIEF.md
# Oversampled SPI Target Interface

This block is an SPI target (slave) for 8-bit, mode 0 frames. It lives entirely in one fast, free-running system clock domain. The serial clock from the bus controller never clocks a flip-flop. The block samples it as an ordinary asynchronous input through a short register chain, then derives rising and falling events by comparing the current sampled level with the previous one. Received data is assembled most significant bit first. When the last bit arrives, the byte appears on a parallel output together with a strobe that lasts one system clock cycle.

The active-low chip select passes through its own synchroniser. While chip select is deasserted, the block ignores the bus, keeps its bit count at zero and reloads the transmit shift register from the parallel transmit input. This puts the leading bit on the serial output before the first rising serial clock edge. Once chip select is seen asserted, the loaded byte is frozen. A frame that ends before its eighth bit produces no strobe, and the next frame starts from bit zero.

Because edges are found by sampling, the serial clock must stay slow enough that each level lasts at least two system clock cycles. This limits it to about one quarter of the system clock rate.

Top module: `spi_os_target`

## Requirements
- R1: The raw serial clock input is read only by the first register of its synchroniser. A rising event is declared when the previous synchronised level is 0 and the current one is 1. A falling event is declared for the opposite transition, and each event lasts a single system clock cycle.
- R2: The serial data input is captured without its own synchroniser, on the system clock edge that ends the cycle in which a rising event is present.
- R3: The serial output changes only on the system clock edge after a falling event inside a frame, and then advances to the next bit of the frame.
- R4: Chip select passes through two synchronising registers. While it is deasserted (high), serial clock edges have no effect: no strobe is produced, and the next frame is received correctly from its first bit.
- R5: The parallel transmit byte present while chip select is deasserted is the byte sent in the frame. Its bit 7 is on the serial output before the first rising serial clock edge, and changes to the transmit input after chip select is seen asserted do not alter the bits sent.
- R6: Bits are received most significant bit first (the first bit of a frame lands in rx_byte bit 7). After the eighth rising event of a frame, rx_byte holds the frame and rx_valid is high for exactly one system clock cycle.
- R7: A frame ended by chip select deassertion before its eighth bit produces no rx_valid pulse, and the following full frame is received and sent correctly.
- R8: While chip select is deasserted, the serial output follows bit 7 of the transmit input, one system clock cycle late.
- R9: Transfers are correct with a serial clock at exactly one quarter of the system clock rate: two system clock cycles low, then two high, with the data input changing on the falling serial clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the only clock used by the block |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial clock from the bus controller, asynchronous |
| mosi_in | input | 1 | Serial data from the bus controller |
| csn_in | input | 1 | Chip select, active low, asynchronous |
| tx_byte | input | WORD_W | Byte to send in the next frame |
| miso_out | output | 1 | Serial data to the bus controller |
| rx_byte | output | WORD_W | Last complete byte received |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_byte |

## Verification
The hardest case to reach from the ports is the minimum timing margin. At one quarter of the system clock rate, the data input is captured only half a system cycle before the controller changes it. The serial output, in turn, settles only half a cycle before the controller samples it. The bench therefore drives every frame at exactly two system cycles low and two high, changes the data input on the same half-cycle as the falling serial clock, and samples the serial output just before raising the clock. This exercises both margins on every bit. It also changes the transmit input in mid-frame, cuts frames short after five bits, and toggles the serial clock with chip select high, each followed by a full frame.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

   // Events derived from one sampled level
   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } lvl_evt_t;

endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("spi_os_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain_q <= RST_VAL;
            else     chain_q <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) chain_q <= {STAGES{RST_VAL}};
            else     chain_q <= {chain_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_os_edge.sv
module spi_os_edge
   import spi_os_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     lvl,
   output lvl_evt_t evt
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= lvl;
   end

   always_comb begin
      evt.level = lvl;
      evt.rise  = lvl & ~prev_q;
      evt.fall  = ~lvl & prev_q;
   end

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      evt.rise |=> !evt.rise); // R1
   AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      evt.fall |=> !evt.fall); // R1
   AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
      (evt.rise && !$past(rst)) |-> !$past(lvl)); // R1

endmodule

// File: rtl/spi_os_shifter.sv
module spi_os_shifter #(
   parameter int WORD_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic              rise,
   input  logic              fall,
   input  logic              mosi,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              miso,
   output logic [WORD_W-1:0] rx_byte,
   output logic              rx_valid
);

   localparam int CNT_W     = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam int FIRST_IDX = MSB_FIRST ? WORD_W - 1 : 0;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("spi_os_shifter: WORD_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] rx_sh_q;
   logic [WORD_W-1:0] tx_sh_q;
   logic [WORD_W-1:0] rx_next;
   logic [WORD_W-1:0] tx_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign rx_next = {rx_sh_q[WORD_W-2:0], mosi};
         assign tx_next = {tx_sh_q[WORD_W-2:0], 1'b0};
      end else begin : g_lsb
         assign rx_next = {mosi, rx_sh_q[WORD_W-1:1]};
         assign tx_next = {1'b0, tx_sh_q[WORD_W-1:1]};
      end
   endgenerate

   assign miso = tx_sh_q[FIRST_IDX];

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         rx_sh_q  <= '0;
         tx_sh_q  <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (!active) begin
            cnt_q   <= '0;
            tx_sh_q <= tx_byte;
         end else begin
            if (rise) begin
               rx_sh_q <= rx_next;
               if (cnt_q == LAST_CNT) begin
                  cnt_q    <= '0;
                  rx_byte  <= rx_next;
                  rx_valid <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            if (fall) tx_sh_q <= tx_next;
         end
      end
   end

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid); // R6
   AST_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> $past(active)); // R4
   AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(active)) |-> (cnt_q == '0)); // R4
   AST_MISO_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(active) && !$past(fall)) |-> $stable(miso)); // R3
   AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(active)) |-> (miso == $past(tx_byte[FIRST_IDX]))); // R8

endmodule

// File: rtl/spi_os_target.sv
module spi_os_target
   import spi_os_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SCLK_STAGES = 1,
   parameter int CS_STAGES   = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk_in,
   input  logic              mosi_in,
   input  logic              csn_in,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              miso_out,
   output logic [WORD_W-1:0] rx_byte,
   output logic              rx_valid
);

   generate
      if (CS_STAGES < 2) begin : g_bad_cs
         $error("spi_os_target: CS_STAGES must be at least 2");
      end
   endgenerate

   logic     sclk_s;
   logic     csn_s;
   logic     frame_on;
   lvl_evt_t sclk_evt;

   // only reader of the raw serial clock pin
   spi_os_sync #(.STAGES(SCLK_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
      .clk (clk),
      .rst (rst),
      .d   (sclk_in),
      .q   (sclk_s)
   );

   spi_os_sync #(.STAGES(CS_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk (clk),
      .rst (rst),
      .d   (csn_in),
      .q   (csn_s)
   );

   assign frame_on = ~csn_s;

   spi_os_edge u_sclk_edge (
      .clk (clk),
      .rst (rst),
      .lvl (sclk_s),
      .evt (sclk_evt)
   );

   spi_os_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .active   (frame_on),
      .rise     (sclk_evt.rise),
      .fall     (sclk_evt.fall),
      .mosi     (mosi_in),
      .tx_byte  (tx_byte),
      .miso     (miso_out),
      .rx_byte  (rx_byte),
      .rx_valid (rx_valid)
   );

   AST_NO_EDGE_CLASH: assert property (@(posedge clk) disable iff (rst)
      !(sclk_evt.rise && sclk_evt.fall)); // R1

endmodule

// File: tb/spi_os_target_tb_top.sv
module spi_os_target_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sclk = 1'b0;
   logic       mosi = 1'b0;
   logic       csn = 1'b1;
   logic [7:0] tx = 8'h00;
   logic       miso;
   logic [7:0] rx_byte;
   logic       rx_valid;

   int checks = 0;
   int fails = 0;
   int pulses = 0;
   int run_len = 0;
   int max_run = 0;
   logic [7:0] last_rx = 8'h00;
   bit done = 0;

   always #2.5 clk = ~clk;

   spi_os_target dut_i (
      .clk      (clk),
      .rst      (rst),
      .sclk_in  (sclk),
      .mosi_in  (mosi),
      .csn_in   (csn),
      .tx_byte  (tx),
      .miso_out (miso),
      .rx_byte  (rx_byte),
      .rx_valid (rx_valid)
   );

   // strobe monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (!rst && rx_valid) begin
         pulses  <= pulses + 1;
         last_rx <= rx_byte;
         run_len <= run_len + 1;
         if (run_len + 1 > max_run) max_run <= run_len + 1;
      end else begin
         run_len <= 0;
      end
   end

   // bit expected at serial position i, MSB first
   function automatic logic bit_at(input logic [7:0] v, input int i);
      return v[7-i];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one frame at clk/4: 2 cycles low, 2 high; data changes on the fall
   task automatic frame(input logic [7:0] m, input logic [7:0] t, input int nb,
                        output logic [7:0] got);
      got = 8'h00;
      tx  = t;
      @(negedge clk);
      csn  = 1'b0;
      mosi = bit_at(m, 0);
      repeat (6) @(negedge clk);
      tx = ~t;                       // late change must be ignored
      for (int i = 0; i < nb; i++) begin
         if (i > 0) begin
            sclk = 1'b0;
            mosi = bit_at(m, i);
         end
         repeat (2) @(negedge clk);
         got[7-i] = miso;
         sclk = 1'b1;
         repeat (2) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      csn = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic full_check(input logic [7:0] m, input logic [7:0] t, input string tag);
      logic [7:0] got;
      int p0;
      p0 = pulses;
      frame(m, t, 8, got);
      check(pulses == p0 + 1, {tag, " R6 one strobe"}, pulses - p0, 1);
      check(last_rx == m, {tag, " R2 R6 rx byte"}, last_rx, m);
      check(got == t, {tag, " R3 R5 R9 miso byte"}, got, t);
   endtask

   initial begin
      logic [7:0] got;
      int p0;
      void'($urandom(32'h5A17));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      tx = 8'h80;
      repeat (3) @(negedge clk);
      check(rx_valid == 1'b0, "reset rx_valid", rx_valid, 0);
      check(miso == 1'b1, "R8 idle miso high", miso, 1);
      tx = 8'h7F;
      repeat (2) @(negedge clk);
      check(miso == 1'b0, "R8 idle miso low", miso, 0);

      // directed patterns (R1 R9 at the minimum margin)
      full_check(8'hA5, 8'h3C, "R1 d0");
      full_check(8'h00, 8'hFF, "R9 d1");
      full_check(8'hFF, 8'h00, "R9 d2");
      full_check(8'h80, 8'h01, "R6 d3");
      full_check(8'h01, 8'h80, "R6 d4");

      // after the frame, tx was inverted: idle miso must follow it
      tx = 8'h55;
      repeat (2) @(negedge clk);
      check(miso == 1'b0, "R8 idle follow", miso, 0);

      // truncated frame
      p0 = pulses;
      frame(8'hC3, 8'h96, 5, got);
      check(pulses == p0, "R7 no strobe on short frame", pulses - p0, 0);
      full_check(8'h5A, 8'hE7, "R7 after short");

      // clock activity while deselected
      p0 = pulses;
      for (int i = 0; i < 8; i++) begin
         mosi = 1'($urandom);
         repeat (2) @(negedge clk);
         sclk = 1'b1;
         repeat (2) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (4) @(negedge clk);
      check(pulses == p0, "R4 no strobe while deselected", pulses - p0, 0);
      full_check(8'h69, 8'hD2, "R4 after idle clocks");

      // random traffic
      for (int k = 0; k < 20; k++) begin
         logic [7:0] m;
         logic [7:0] t;
         m = 8'($urandom);
         t = 8'($urandom);
         full_check(m, t, "rand");
      end

      check(max_run == 1, "R6 strobe width", max_run, 1);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule